// File: doc/BRIEF.md
# Monitor Channel Byte Receiver

This block is the receiving end of a byte-wide maintenance channel that is carried inside a repeating frame. Once per frame a strobe presents one data byte and the transmitter's active-low "byte present" flag (MX). The block answers with an active-low acknowledge flag (MR) that goes back to the transmitter in the next frame. The transmitter repeats a byte every frame until the receiver acknowledges it. The receiver takes a byte only after the same value has been seen in two consecutive frames, which filters single-frame corruption.

Verified bytes leave through a one-beat valid/ready slot. The first byte of a message carries a start marker. The end of a message is delivered as a separate beat that carries the end marker and a zero data byte. When the slot is still occupied, the receiver withholds the acknowledge, so the transmitter keeps repeating its byte. This is the only means of flow control. A gap of exactly one frame in MX inside a message is an abort: the partial message is discarded and a one-cycle abort flag is raised. A run of frames in which both flags are inactive is reported as idle, and it closes any message in progress.

The frame-level byte is assumed to be assembled already, most significant bit first, by the framing logic. Within one message, consecutive bytes must differ in value, because the receiver detects the next byte by its change. A receiving block does not transmit, so half-duplex use is implied.

Top module: `mon_byte_rx`

## Requirements
- R1: After reset, mon_mr_n is 1, rx_valid is 0, rx_idle is 0 and rx_abort is 0.
- R2: rx_idle becomes 1 at the strobe that completes IDLE_FRAMES (default 2) consecutive frames with mon_mx_n=1 while mon_mr_n=1. It returns to 0 at the first strobe that breaks that condition.
- R3: A frame with mon_mx_n=0 outside a message starts a message. The first byte delivered after that, or after an abort, has rx_som=1. Later bytes have rx_som=0.
- R4: A byte is accepted only at a strobe where mon_mx_n=0 and the byte equals the byte of the immediately preceding frame, which also had mon_mx_n=0. A differing value restarts the comparison with the new value.
- R5: At the strobe that accepts a byte, mon_mr_n goes to 0. It returns to 1 at the first later strobe where mon_mx_n=1 or the byte differs from the previous frame's byte. mon_mr_n changes only on strobe edges.
- R6: While the output slot holds an undelivered beat, no byte is accepted and mon_mr_n stays 1.
- R7: At the strobe that completes the idle run inside a message, an end beat (rx_eom=1, rx_som=0, rx_data=0) is queued. It is presented once the slot is empty.
- R8: In a message, a strobe with mon_mx_n=0 that follows a run of 1 to IDLE_FRAMES-1 fully inactive frames is an abort. It pulses rx_abort for one cycle, discards any undelivered beat or pending end beat, and begins a new message whose first look is that frame's byte.
- R9: While rx_valid=1 and rx_ready=0, rx_valid, rx_data, rx_som and rx_eom hold, unless an abort discards the beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_stb | input | 1 | One-cycle strobe per frame; samples the inputs and updates the acknowledge |
| mon_byte | input | DATA_W | Byte carried in this frame |
| mon_mx_n | input | 1 | Transmitter byte-present flag, 0 = active |
| mon_mr_n | output | 1 | Receiver acknowledge flag, 0 = active |
| rx_valid | output | 1 | Output beat valid |
| rx_ready | input | 1 | Downstream can take the beat |
| rx_data | output | DATA_W | Verified byte (0 on end beat) |
| rx_som | output | 1 | Beat is the first byte of a message |
| rx_eom | output | 1 | Beat marks end of message |
| rx_idle | output | 1 | Channel idle |
| rx_abort | output | 1 | One-cycle pulse on abort |

## Verification
The hardest state to reach from the ports is a collision between an abort and a full output slot holding an end beat that is still pending. To get there, the downstream ready is held low across a message, so the acknowledge is withheld and the end beat stacks up behind a stalled byte. The transmitter then opens a one-frame MX gap in the next message. A reactive transmitter task watches mon_mr_n and drives the timing of the gaps and repeats. A behavioural frame model in the bench predicts every output on every clock.

// File: rtl/mon_rx_pkg.sv
package mon_rx_pkg;

  typedef enum logic [1:0] {
    RX_IDLE = 2'd0,
    RX_HUNT = 2'd1,
    RX_ACK  = 2'd2
  } rx_state_e;

  // Gap of at least one inactive frame that has not yet become idle.
  function automatic logic gap_partial(input int cnt, input int lim);
    return (cnt > 0) && (cnt < lim);
  endfunction

  // Saturating increment of the inactive-frame count.
  function automatic int count_step(input int cnt, input int lim, input logic inact);
    if (!inact) return 0;
    return (cnt >= lim) ? lim : cnt + 1;
  endfunction

endpackage

// File: rtl/mon_rx_idle.sv
module mon_rx_idle import mon_rx_pkg::*; #(
  parameter int IDLE_FRAMES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stb,
  input  logic mx_n,
  input  logic mr_n,
  output logic idle,
  output logic gap_open,
  output logic gap_done
);
  localparam int CNT_W = $clog2(IDLE_FRAMES + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             inact;

  assign inact    = mx_n && mr_n;
  assign idle     = int'(cnt_q) >= IDLE_FRAMES;
  assign gap_open = gap_partial(int'(cnt_q), IDLE_FRAMES);
  assign gap_done = inact && (int'(cnt_q) == IDLE_FRAMES - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (stb) begin
      cnt_q <= CNT_W'(count_step(int'(cnt_q), IDLE_FRAMES, inact));
    end
  end
endmodule

// File: rtl/mon_rx_lastlook.sv
module mon_rx_lastlook #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stb,
  input  logic              mx_n,
  input  logic [DATA_W-1:0] din,
  output logic              pair_match,
  output logic              byte_moved
);
  logic [DATA_W-1:0] cand_q;
  logic              cand_vld_q;

  assign pair_match = stb && !mx_n && cand_vld_q && (din == cand_q);
  assign byte_moved = din != cand_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cand_q     <= '0;
      cand_vld_q <= 1'b0;
    end else if (stb) begin
      if (mx_n) begin
        cand_vld_q <= 1'b0;
      end else begin
        cand_q     <= din;
        cand_vld_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/mon_rx_slot.sv
module mon_rx_slot #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_byte,
  input  logic              load_som,
  input  logic [DATA_W-1:0] din,
  input  logic              eom_req,
  input  logic              flush,
  input  logic              ready,
  output logic              free,
  output logic              valid,
  output logic [DATA_W-1:0] data,
  output logic              som,
  output logic              eom
);
  logic eom_pend_q;
  logic fire;
  logic emit_eom;

  assign fire     = valid && ready;
  assign free     = !valid && !eom_pend_q;
  assign emit_eom = eom_pend_q && !valid && !load_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid      <= 1'b0;
      data       <= '0;
      som        <= 1'b0;
      eom        <= 1'b0;
      eom_pend_q <= 1'b0;
    end else if (flush) begin
      valid      <= 1'b0;
      eom_pend_q <= 1'b0;
    end else begin
      if (fire) valid <= 1'b0;
      if (load_byte) begin
        valid <= 1'b1;
        data  <= din;
        som   <= load_som;
        eom   <= 1'b0;
      end else if (emit_eom) begin
        valid <= 1'b1;
        data  <= '0;
        som   <= 1'b0;
        eom   <= 1'b1;
      end
      if (eom_req)       eom_pend_q <= 1'b1;
      else if (emit_eom) eom_pend_q <= 1'b0;
    end
  end
endmodule

// File: rtl/mon_byte_rx.sv
module mon_byte_rx import mon_rx_pkg::*; #(
  parameter int DATA_W      = 8,
  parameter int IDLE_FRAMES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_stb,
  input  logic [DATA_W-1:0] mon_byte,
  input  logic              mon_mx_n,
  output logic              mon_mr_n,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_som,
  output logic              rx_eom,
  output logic              rx_idle,
  output logic              rx_abort
);
  rx_state_e st_q;
  logic      mr_q;
  logic      som_pend_q;
  logic      abort_q;

  logic gap_open, gap_done;
  logic pair_match, byte_moved;
  logic slot_free;
  logic in_hunt;
  logic abort_evt, eom_evt, accept_evt, release_evt, start_evt;

  mon_rx_idle #(.IDLE_FRAMES(IDLE_FRAMES)) u_idle (
    .clk(clk), .rst_n(rst_n), .stb(frame_stb), .mx_n(mon_mx_n), .mr_n(mr_q),
    .idle(rx_idle), .gap_open(gap_open), .gap_done(gap_done)
  );

  mon_rx_lastlook #(.DATA_W(DATA_W)) u_look (
    .clk(clk), .rst_n(rst_n), .stb(frame_stb), .mx_n(mon_mx_n), .din(mon_byte),
    .pair_match(pair_match), .byte_moved(byte_moved)
  );

  mon_rx_slot #(.DATA_W(DATA_W)) u_slot (
    .clk(clk), .rst_n(rst_n), .load_byte(accept_evt), .load_som(som_pend_q),
    .din(mon_byte), .eom_req(eom_evt), .flush(abort_evt), .ready(rx_ready),
    .free(slot_free), .valid(rx_valid), .data(rx_data), .som(rx_som), .eom(rx_eom)
  );

  always_comb begin
    in_hunt     = frame_stb && (st_q == RX_HUNT);
    start_evt   = frame_stb && (st_q == RX_IDLE) && !mon_mx_n;
    abort_evt   = in_hunt && !mon_mx_n && gap_open;
    eom_evt     = in_hunt && !abort_evt && gap_done;
    accept_evt  = in_hunt && !abort_evt && !eom_evt && pair_match && slot_free;
    release_evt = frame_stb && (st_q == RX_ACK) && (mon_mx_n || byte_moved);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= RX_IDLE;
      mr_q       <= 1'b1;
      som_pend_q <= 1'b0;
      abort_q    <= 1'b0;
    end else begin
      abort_q <= abort_evt;
      if (start_evt) begin
        st_q       <= RX_HUNT;
        som_pend_q <= 1'b1;
      end else if (abort_evt) begin
        som_pend_q <= 1'b1;
      end else if (eom_evt) begin
        st_q <= RX_IDLE;
      end else if (accept_evt) begin
        st_q       <= RX_ACK;
        mr_q       <= 1'b0;
        som_pend_q <= 1'b0;
      end else if (release_evt) begin
        st_q <= RX_HUNT;
        mr_q <= 1'b1;
      end
    end
  end

  assign mon_mr_n = mr_q;
  assign rx_abort = abort_q;
endmodule

module mon_byte_rx_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_stb,
  input logic              mon_mr_n,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic [DATA_W-1:0] rx_data,
  input logic              rx_som,
  input logic              rx_eom,
  input logic              rx_idle,
  input logic              rx_abort,
  input logic              pair_match,
  input logic              slot_free,
  input logic              abort_evt
);
  AST_MR_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(frame_stb) |-> $stable(mon_mr_n)); // R5
  AST_ACK_AFTER_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mon_mr_n) |-> $past(pair_match)); // R4
  AST_ACK_SLOT_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mon_mr_n) |-> $past(slot_free)); // R6
  AST_IDLE_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    rx_idle |-> mon_mr_n); // R2
  AST_MARKERS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> !(rx_som && rx_eom)); // R7
  AST_EOM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_eom) |-> (rx_data == '0)); // R7
  AST_ABORT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_abort |=> !rx_abort); // R8
  AST_HOLD_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready && !abort_evt) |=>
      (rx_valid && $stable(rx_data) && $stable(rx_som) && $stable(rx_eom))); // R9
endmodule

bind mon_byte_rx mon_byte_rx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .mon_mr_n(mon_mr_n),
  .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data), .rx_som(rx_som),
  .rx_eom(rx_eom), .rx_idle(rx_idle), .rx_abort(rx_abort),
  .pair_match(pair_match), .slot_free(slot_free), .abort_evt(abort_evt)
);

// File: tb/mon_byte_rx_tb.sv
module mon_byte_rx_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_stb = 1'b0;
  logic [7:0] mon_byte = 8'h00;
  logic       mon_mx_n = 1'b1;
  logic       rx_ready = 1'b1;
  logic       mon_mr_n, rx_valid, rx_som, rx_eom, rx_idle, rx_abort;
  logic [7:0] rx_data;

  int total = 0;
  int bad = 0;
  int rdy_mode = 0;   // 0 always ready, 1 stalled, 2 alternating
  bit done = 0;
  int aborts_seen = 0;
  int eoms_seen = 0;

  always #10 clk = ~clk;  // 50 MHz

  mon_byte_rx u_dut (
    .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .mon_byte(mon_byte),
    .mon_mx_n(mon_mx_n), .mon_mr_n(mon_mr_n), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .rx_som(rx_som), .rx_eom(rx_eom), .rx_idle(rx_idle),
    .rx_abort(rx_abort)
  );

  // ---------------- behavioural frame model ----------------
  int         m_phase;      // 0 no message, 1 waiting for pair, 2 acknowledging
  int         m_quiet;      // consecutive frames with both flags inactive
  bit         m_ack_n, m_first, m_abort, m_have, m_pend;
  int         m_prev;
  bit         m_v, m_s, m_e;
  int         m_d;
  int         beats[$];     // log of delivered data bytes

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_quiet = 0; m_ack_n = 1; m_first = 0; m_abort = 0;
      m_have = 0; m_pend = 0; m_prev = 0; m_v = 0; m_s = 0; m_e = 0; m_d = 0;
    end else begin
      bit was_v, was_p, room, take, want_end, kill, both_off;
      was_v = m_v; was_p = m_pend; room = !m_v && !m_pend;
      take = 0; want_end = 0; kill = 0; m_abort = 0;
      if (frame_stb) begin
        both_off = mon_mx_n && m_ack_n;
        case (m_phase)
          0: if (!mon_mx_n) begin m_phase = 1; m_first = 1; end
          1: begin
            if (!mon_mx_n && m_quiet == 1) begin
              kill = 1; m_abort = 1; m_first = 1;
            end else if (both_off && m_quiet == 1) begin
              want_end = 1; m_phase = 0;
            end else if (!mon_mx_n && m_have && int'(mon_byte) == m_prev && room) begin
              take = 1; m_ack_n = 0; m_phase = 2;
            end
          end
          default: if (mon_mx_n || int'(mon_byte) != m_prev) begin
            m_ack_n = 1; m_phase = 1;
          end
        endcase
        m_quiet = both_off ? ((m_quiet >= 2) ? 2 : m_quiet + 1) : 0;
        if (mon_mx_n) m_have = 0;
        else begin m_have = 1; m_prev = int'(mon_byte); end
      end
      if (kill) begin
        m_v = 0; m_pend = 0;
      end else begin
        if (was_v && rx_ready) m_v = 0;
        if (take) begin
          m_v = 1; m_d = int'(mon_byte); m_s = m_first; m_e = 0; m_first = 0;
        end else if (was_p && !was_v) begin
          m_v = 1; m_d = 0; m_s = 0; m_e = 1; m_pend = 0;
        end
        if (want_end) m_pend = 1;
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // every-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R5 mon_mr_n", int'(mon_mr_n), int'(m_ack_n));
      chk("R2 rx_idle", int'(rx_idle), int'(m_quiet >= 2));
      chk("R8 rx_abort", int'(rx_abort), int'(m_abort));
      chk("R4 rx_valid", int'(rx_valid), int'(m_v));
      if (rx_valid && m_v) begin
        chk("R4 rx_data", int'(rx_data), m_d);
        chk("R3 rx_som", int'(rx_som), int'(m_s));
        chk("R7 rx_eom", int'(rx_eom), int'(m_e));
      end
      if (rx_abort) aborts_seen++;
      if (rx_valid && rx_ready) begin
        if (rx_eom) eoms_seen++; else beats.push_back(int'(rx_data));
      end
    end
  end

  int cyc = 0;
  always @(negedge clk) begin
    cyc++;
    case (rdy_mode)
      0: rx_ready = 1'b1;
      1: rx_ready = 1'b0;
      default: rx_ready = cyc[0];
    endcase
  end

  // one frame: four clocks, strobe in the first
  task automatic frame(input bit mx_n, input logic [7:0] b);
    @(negedge clk);
    mon_mx_n = mx_n; mon_byte = b; frame_stb = 1'b1;
    @(negedge clk);
    frame_stb = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // reactive transmitter: repeat each byte until acknowledged
  task automatic send_msg(input int n, input logic [7:0] base);
    for (int i = 0; i < n; i++) begin
      int tries = 0;
      do begin
        frame(1'b0, base + 8'(i * 5));
        tries++;
      end while (mon_mr_n && tries < 40);
    end
    repeat (3) frame(1'b1, 8'h00);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values
    chk("R1 mr", int'(mon_mr_n), 1);
    chk("R1 valid", int'(rx_valid), 0);
    chk("R1 idle", int'(rx_idle), 0);
    chk("R1 abort", int'(rx_abort), 0);
    rst_n = 1'b1;
    // R2: idle after two inactive frames
    frame(1'b1, 8'h00);
    chk("R2 not yet idle", int'(rx_idle), 0);
    frame(1'b1, 8'h00);
    chk("R2 idle", int'(rx_idle), 1);
    // R3 R5 R7: plain message
    send_msg(3, 8'h31);
    // R4: first look differs, then a matching pair
    frame(1'b0, 8'hA0);
    frame(1'b0, 8'hA5);
    chk("R4 no accept on mismatch", int'(mon_mr_n), 1);
    frame(1'b0, 8'hA5);
    chk("R4 accept on pair", int'(mon_mr_n), 0);
    frame(1'b0, 8'hA5);
    chk("R5 ack held while byte repeats", int'(mon_mr_n), 0);
    frame(1'b0, 8'hB6);
    chk("R5 ack released on new byte", int'(mon_mr_n), 1);
    frame(1'b0, 8'hB6);
    repeat (3) frame(1'b1, 8'h00);
    // R6: stall downstream, acknowledge withheld
    rdy_mode = 1;
    frame(1'b0, 8'h11);
    frame(1'b0, 8'h11);
    frame(1'b0, 8'h22);
    repeat (8) frame(1'b0, 8'h22);
    chk("R6 ack withheld while slot full", int'(mon_mr_n), 1);
    chk("R9 beat held", int'(rx_data), 8'h11);
    rdy_mode = 0;
    frame(1'b0, 8'h22);
    frame(1'b0, 8'h22);
    repeat (3) frame(1'b1, 8'h00);
    // R8: abort with stalled slot and pending end beat
    rdy_mode = 1;
    frame(1'b0, 8'h40); frame(1'b0, 8'h40);
    repeat (3) frame(1'b1, 8'h00);
    frame(1'b0, 8'h50); frame(1'b0, 8'h55);
    frame(1'b1, 8'h00); frame(1'b1, 8'h00);
    frame(1'b0, 8'h60); frame(1'b0, 8'h60);
    frame(1'b1, 8'h00);
    frame(1'b0, 8'h70);
    @(negedge clk);
    chk("R8 abort flushed slot", int'(rx_valid), 0);
    rdy_mode = 0;
    frame(1'b0, 8'h70);
    frame(1'b0, 8'h75);
    frame(1'b0, 8'h75);
    repeat (3) frame(1'b1, 8'h00);
    // alternating ready through a longer message
    rdy_mode = 2;
    send_msg(5, 8'h81);
    rdy_mode = 0;
    repeat (6) frame(1'b1, 8'h00);
    chk("R8 aborts seen", int'(aborts_seen > 0), 1);
    chk("R7 end beats seen", int'(eoms_seen >= 4), 1);
    chk("R3 bytes delivered", int'(beats.size() >= 10), 1);
    finish_run();
  end
endmodule